// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block turns single requests from an internal requester into timed access cycles on an external asynchronous memory port, such as SRAM, NOR flash or a NAND-style device. A request carries a read/write flag, a chip-select index, a bank, an address, byte-lane enables and write data. The requester holds the request until the block pulses `rsp_ready`. Every access goes through three phases: setup, strobe and hold. A quiet turnaround gap follows each access.

Each of the chip-select spaces has its own 31-bit timing word. The word sets separate setup, strobe and hold counts for reads and for writes, a turnaround count, a select-strobe mode flag and an extended-wait flag. The block copies the timing word when it accepts a request, so software can rewrite it at any time without damaging an access that is already running. In extended-wait mode the external device can stretch the strobe with a wait input. A global limit bounds the stretch; when the limit is reached the access completes and reports a timeout.

Top module: `amem_strobe_seq`

## Requirements
- R1: While reset is low and right after it, every chip select, `mem_oe_n` and `mem_we_n` are high, `mem_den` is low and `rsp_ready` is low.
- R2: The timing word for space i sits at `cfg_timing[31*i +: 31]`. Its fields are: read setup [3:0], read strobe [9:4], read hold [12:10], write setup [16:13], write strobe [22:17], write hold [25:23], turnaround [28:26], select-strobe [29] and extended-wait [30]. With select-strobe clear, the chip select is asserted for (setup+1) cycles before the strobe falls.
- R3: A read drives `mem_oe_n` low and a write drives `mem_we_n` low for the strobe count in cycles. A strobe count of 0 gives one cycle. The two strobes are never low together.
- R4: After the strobe rises, the chip select stays asserted for (hold+1) cycles when select-strobe is clear.
- R5: When a new request is waiting at the end of an access, exactly (turnaround+1) cycles pass with every chip select and strobe inactive before the next access begins.
- R6: With select-strobe set, the chip select is low in exactly the cycles in which the strobe is low.
- R7: Only the chip select chosen by `req_cs` goes low. Address, bank and byte enables stay constant for the whole access.
- R8: Read data is sampled from `mem_din` on the clock edge where the strobe rises. `rsp_ready` is high for exactly one cycle per access, and `rsp_rdata` is valid in that cycle.
- R9: `mem_den` is high for the whole write, from setup through hold, with `mem_dout` equal to the write data. It is never high during a read.
- R10: With extended-wait set, `mem_wait` passes through a two-flop synchronizer. If it is already high when the nominal strobe ends, the strobe continues until the synchronized wait is low. Dropping `mem_wait` during strobe cycle K, where K is at least the nominal count, gives a strobe of K+2 cycles.
- R11: When the wait is still high after `cfg_max_wait` extra cycles beyond the nominal strobe, the access completes with `rsp_timeout` high alongside `rsp_ready`.
- R12: With extended-wait clear, `mem_wait` has no effect on the strobe length and `rsp_timeout` stays low.
- R13: A change to `cfg_timing` while an access is running does not alter that access. It applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until `rsp_ready` |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | 2 | Chip-select space index |
| req_bank | input | 2 | Bank address |
| req_addr | input | 22 | Word address |
| req_be | input | 2 | Byte-lane enables, active high |
| req_wdata | input | 16 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Wait limit reached, valid with `rsp_ready` |
| rsp_rdata | output | 16 | Read data |
| cfg_timing | input | 124 | Four 31-bit timing words |
| cfg_max_wait | input | 8 | Maximum extra strobe cycles under wait |
| mem_cs_n | output | 4 | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 1 | Write enable (write strobe), active low |
| mem_ba | output | 2 | Bank lines |
| mem_addr | output | 22 | Address lines |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_dout | output | 16 | Data to memory |
| mem_den | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Data from memory |
| mem_wait | input | 1 | External wait, active high, asynchronous |

## Verification
The hardest cases to reach are the stretched strobe and its release. The synchronizer delays the wait input by two cycles, so the cycle in which the strobe ends depends on when the wait falls relative to the nominal strobe end. The bench counts strobe cycles at the pins and releases the wait at a chosen count. It also holds the wait high past the limit to force the timeout. To reach the turnaround gap, the bench presents a second request in the same cycle that it sees the first completion. To check that configuration is latched, the bench rewrites the timing word while the setup phase is running.

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq #(
  parameter int NCS = 4,
  parameter int AW  = 22,
  parameter int BAW = 2,
  parameter int DW  = 16,
  parameter int SW  = 4,
  parameter int STW = 6,
  parameter int HW  = 3,
  parameter int TAW = 3,
  parameter int MWW = 8,
  localparam int CSW  = $clog2(NCS),
  localparam int BEW  = DW / 8,
  localparam int PW   = SW + STW + HW,
  localparam int TA_O = 2 * PW,
  localparam int SS_O = TA_O + TAW,
  localparam int EW_O = SS_O + 1,
  localparam int CFGW = EW_O + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [BAW-1:0]    req_bank,
  input  logic [AW-1:0]     req_addr,
  input  logic [BEW-1:0]    req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_ready,
  output logic              rsp_timeout,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [NCS*CFGW-1:0] cfg_timing,
  input  logic [MWW-1:0]    cfg_max_wait,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [BAW-1:0]    mem_ba,
  output logic [AW-1:0]     mem_addr,
  output logic [BEW-1:0]    mem_be_n,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_den,
  input  logic [DW-1:0]     mem_din,
  input  logic              mem_wait
);

  localparam int CW0 = (SW > STW) ? SW : STW;
  localparam int CW1 = (HW > TAW) ? HW : TAW;
  localparam int CW  = (CW0 > CW1) ? CW0 : CW1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD, S_TURN} state_t;

  state_t           state;
  logic [CW-1:0]    cnt;
  logic [MWW-1:0]   wcnt;
  logic [1:0]       wsync;
  logic             wait_s;
  logic             cur_wr, cur_ss, cur_ew;
  logic [CSW-1:0]   cur_cs;
  logic [BAW-1:0]   cur_ba;
  logic [AW-1:0]    cur_addr;
  logic [BEW-1:0]   cur_be;
  logic [DW-1:0]    cur_wd;
  logic [STW-1:0]   cur_st;
  logic [HW-1:0]    cur_hd;
  logic [TAW-1:0]   cur_ta;
  logic [MWW-1:0]   cur_maxw;

  logic [CFGW-1:0]  cfg_sel;
  logic [PW-1:0]    ph_sel;
  logic             accept, in_acc, cs_on, wait_hit;

  assign cfg_sel = cfg_timing[req_cs*CFGW +: CFGW];
  assign ph_sel  = req_write ? cfg_sel[PW +: PW] : cfg_sel[0 +: PW];
  assign accept  = req_valid && (state == S_IDLE || (state == S_TURN && cnt == '0));
  assign wait_s  = wsync[1];
  assign wait_hit = cur_ew && wait_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsync <= '0;
    else        wsync <= {wsync[0], mem_wait};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_wr <= 1'b0; cur_ss <= 1'b0; cur_ew <= 1'b0;
      cur_cs <= '0; cur_ba <= '0; cur_addr <= '0; cur_be <= '0; cur_wd <= '0;
      cur_st <= '0; cur_hd <= '0; cur_ta <= '0; cur_maxw <= '0;
    end else if (accept) begin
      cur_wr   <= req_write;
      cur_cs   <= req_cs;
      cur_ba   <= req_bank;
      cur_addr <= req_addr;
      cur_be   <= req_be;
      cur_wd   <= req_wdata;
      cur_st   <= ph_sel[SW +: STW];
      cur_hd   <= ph_sel[SW+STW +: HW];
      cur_ta   <= cfg_sel[TA_O +: TAW];
      cur_ss   <= cfg_sel[SS_O];
      cur_ew   <= cfg_sel[EW_O];
      cur_maxw <= cfg_max_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      wcnt <= '0;
      rsp_ready <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= 1'b0;
      if (accept) begin
        state <= S_SETUP;
        cnt   <= CW'(ph_sel[0 +: SW]);
      end else begin
        case (state)
          S_SETUP:
            if (cnt == '0) begin
              state <= S_STRB;
              cnt   <= (cur_st == '0) ? '0 : CW'(cur_st - 1'b1);
              wcnt  <= '0;
            end else cnt <= cnt - 1'b1;
          S_STRB:
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (wait_hit && wcnt != cur_maxw) wcnt <= wcnt + 1'b1;
            else begin
              state       <= S_HOLD;
              cnt         <= CW'(cur_hd);
              rsp_ready   <= 1'b1;
              rsp_timeout <= wait_hit;
              if (!cur_wr) rsp_rdata <= mem_din;
            end
          S_HOLD:
            if (cnt == '0) begin
              state <= S_TURN;
              cnt   <= CW'(cur_ta);
            end else cnt <= cnt - 1'b1;
          S_TURN:
            if (cnt == '0) state <= S_IDLE;
            else cnt <= cnt - 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign in_acc = (state == S_SETUP) || (state == S_STRB) || (state == S_HOLD);
  assign cs_on  = cur_ss ? (state == S_STRB) : in_acc;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_cs_n[i] = !(cs_on && cur_cs == CSW'(i));
  end

  assign mem_oe_n = !(state == S_STRB && !cur_wr);
  assign mem_we_n = !(state == S_STRB && cur_wr);
  assign mem_ba   = cur_ba;
  assign mem_addr = cur_addr;
  assign mem_be_n = in_acc ? ~cur_be : '1;
  assign mem_den  = in_acc && cur_wr;
  assign mem_dout = cur_wd;

  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  p_den_not_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_den |-> mem_oe_n);
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);
  p_turn_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TURN) |-> (&mem_cs_n && mem_oe_n && mem_we_n && !mem_den));
  p_ss_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && cur_ss) |-> ((&mem_cs_n) == (mem_oe_n && mem_we_n)));
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STRB) |-> ($stable(mem_addr) && $stable(mem_ba)));
  p_wait_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STRB) |-> (wcnt <= cur_maxw));
  p_timeout_ew_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && rsp_timeout) |-> cur_ew);

endmodule

// File: tb/amem_strobe_seq_bench.sv
module amem_strobe_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_cs = 0, req_bank = 0;
  logic [21:0] req_addr = 0;
  logic [1:0]  req_be = 0;
  logic [15:0] req_wdata = 0;
  logic        rsp_ready, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic [123:0] cfg_timing = '0;
  logic [7:0]  cfg_max_wait = 8'd20;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_den;
  logic [1:0]  mem_ba, mem_be_n;
  logic [21:0] mem_addr;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = 16'h0;
  logic        mem_wait = 1'b0;

  amem_strobe_seq u_amem_strobe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_bank(req_bank), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_timeout(rsp_timeout),
    .rsp_rdata(rsp_rdata), .cfg_timing(cfg_timing), .cfg_max_wait(cfg_max_wait),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
    .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_dout(mem_dout), .mem_den(mem_den),
    .mem_din(mem_din), .mem_wait(mem_wait));

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] mkcfg(input int rs, rst, rh, ws, wst, wh, ta, ss, ew);
    logic [30:0] c;
    c = '0;
    c[3:0] = 4'(rs);   c[9:4] = 6'(rst);   c[12:10] = 3'(rh);
    c[16:13] = 4'(ws); c[22:17] = 6'(wst); c[25:23] = 3'(wh);
    c[28:26] = 3'(ta); c[29] = 1'(ss);     c[30] = 1'(ew);
    return c;
  endfunction

  // pin monitor
  int m_setup, m_strb, m_hold, m_den, m_csl, m_mism, m_gap, m_last_gap, m_rdy;
  bit m_seen, m_act_prev, m_addr_chg, m_dout_bad, m_tmo;
  logic [3:0] m_csmask;
  logic [21:0] m_a0;
  logic [15:0] m_rd;
  logic [15:0] m_wd_exp;

  always @(negedge clk) begin
    bit act, strb;
    if (rst_n) begin
      strb = !mem_oe_n || !mem_we_n;
      act = (mem_cs_n != 4'hF) || strb;
      if (act && !m_act_prev) begin
        m_last_gap = m_gap;
        m_setup = 0; m_strb = 0; m_hold = 0; m_den = 0; m_csl = 0; m_mism = 0;
        m_seen = 0; m_addr_chg = 0; m_dout_bad = 0; m_csmask = '0; m_a0 = mem_addr; m_rdy = 0;
      end
      if (act) begin
        if (strb) begin m_strb++; m_seen = 1; end
        else if (!m_seen) m_setup++;
        else m_hold++;
        if (mem_cs_n != 4'hF) m_csl++;
        if ((mem_cs_n != 4'hF) != strb) m_mism++;
        m_csmask |= ~mem_cs_n;
        if (mem_addr != m_a0) m_addr_chg = 1;
        if (!mem_we_n && mem_dout != m_wd_exp) m_dout_bad = 1;
      end else m_gap = m_act_prev ? 1 : m_gap + 1;
      if (mem_den) m_den++;
      if (rsp_ready) begin m_rdy++; m_rd = rsp_rdata; m_tmo = rsp_timeout; end
      m_act_prev = act;
    end
  end

  task automatic set_cfg(input int cs, input logic [30:0] c);
    cfg_timing[cs*31 +: 31] = c;
  endtask

  task automatic drive_req(input bit wr, input int cs, input int addr, input int wd);
    req_valid = 1; req_write = wr; req_cs = 2'(cs); req_bank = 2'(cs);
    req_addr = 22'(addr); req_be = 2'b11; req_wdata = 16'(wd); m_wd_exp = 16'(wd);
  endtask

  task automatic wait_ready(input int rel_k);
    int k = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!mem_oe_n || !mem_we_n) k++;
      if (rel_k != 0 && k == rel_k) mem_wait = 0;
      if (rsp_ready) return;
    end
    chk(0, "ready never seen", 0, 1);
  endtask

  task automatic access(input bit wr, input int cs, input int addr, input int wd, input int rel_k);
    drive_req(wr, cs, addr, wd);
    wait_ready(rel_k);
    req_valid = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && !mem_den && !rsp_ready, "R1 in reset", 0, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && !mem_den && !rsp_ready, "R1 after reset", 0, 1);
  endtask

  task automatic t_read;
    mem_din = 16'hA5C3;
    access(0, 0, 22'h2ABCD, 0, 0);
    chk(m_setup == 3, "R2 read setup", m_setup, 3);
    chk(m_strb == 4, "R3 read strobe", m_strb, 4);
    chk(m_hold == 2, "R4 read hold", m_hold, 2);
    chk(m_rdy == 1, "R8 ready count", m_rdy, 1);
    chk(m_rd == 16'hA5C3, "R8 read data", m_rd, 16'hA5C3);
    chk(m_den == 0, "R9 no den on read", m_den, 0);
    chk(m_csmask == 4'b0001 && !m_addr_chg, "R7 cs0 and address", m_csmask, 1);
  endtask

  task automatic t_write;
    access(1, 1, 22'h01234, 16'h5A17, 0);
    chk(m_setup == 1, "R2 write setup", m_setup, 1);
    chk(m_strb == 2, "R3 write strobe", m_strb, 2);
    chk(m_hold == 1, "R4 write hold", m_hold, 1);
    chk(m_den == 4, "R9 den window", m_den, 4);
    chk(!m_dout_bad, "R9 write data", 0, 0);
    chk(m_csmask == 4'b0010 && !m_addr_chg, "R7 cs1 and address", m_csmask, 2);
  endtask

  task automatic t_zero_strobe;
    access(0, 2, 22'h10, 0, 0);
    chk(m_strb == 1, "R3 zero strobe", m_strb, 1);
    chk(m_csmask == 4'b0100, "R7 cs2", m_csmask, 4);
  endtask

  task automatic t_b2b(input int ta, input int rst);
    set_cfg(0, mkcfg(0, rst, 0, 1, 3, 2, ta, 0, 0));
    drive_req(0, 0, 22'h40, 0);
    wait_ready(0);
    drive_req(0, 0, 22'h44, 0);
    repeat (2) @(negedge clk);
    wait_ready(0);
    req_valid = 0;
    repeat (10) @(negedge clk);
    chk(m_last_gap == ta + 1, "R5 turnaround gap", m_last_gap, ta + 1);
  endtask

  task automatic t_ss;
    access(0, 3, 22'h77, 0, 0);
    chk(m_csl == 5 && m_strb == 5, "R6 cs equals strobe count", m_csl, 5);
    chk(m_mism == 0 && m_setup == 0, "R6 cs only in strobe", m_mism, 0);
  endtask

  task automatic t_wait_release;
    set_cfg(2, mkcfg(1, 3, 1, 1, 3, 1, 0, 0, 1));
    cfg_max_wait = 8'd20;
    mem_wait = 1;
    repeat (3) @(negedge clk);
    access(0, 2, 22'h99, 0, 6);
    chk(m_strb == 8, "R10 stretched strobe", m_strb, 8);
    chk(m_tmo == 0, "R10 no timeout", m_tmo, 0);
  endtask

  task automatic t_timeout;
    cfg_max_wait = 8'd4;
    mem_wait = 1;
    repeat (3) @(negedge clk);
    drive_req(0, 2, 22'h9A, 0);
    wait_ready(0);
    req_valid = 0;
    mem_wait = 0;
    repeat (10) @(negedge clk);
    chk(m_strb == 7, "R11 strobe at timeout", m_strb, 7);
    chk(m_tmo == 1, "R11 timeout flag", m_tmo, 1);
  endtask

  task automatic t_ew_off;
    set_cfg(0, mkcfg(2, 4, 1, 1, 3, 2, 2, 0, 0));
    mem_wait = 1;
    repeat (3) @(negedge clk);
    drive_req(0, 0, 22'h5, 0);
    wait_ready(0);
    req_valid = 0;
    mem_wait = 0;
    repeat (10) @(negedge clk);
    chk(m_strb == 4, "R12 wait ignored", m_strb, 4);
    chk(m_tmo == 0, "R12 no timeout", m_tmo, 0);
  endtask

  task automatic t_cfg_latch;
    set_cfg(0, mkcfg(2, 4, 1, 1, 3, 2, 2, 0, 0));
    drive_req(0, 0, 22'h8, 0);
    repeat (2) @(negedge clk);
    set_cfg(0, mkcfg(2, 9, 1, 1, 3, 2, 2, 0, 0));
    wait_ready(0);
    req_valid = 0;
    repeat (10) @(negedge clk);
    chk(m_strb == 4, "R13 old timing kept", m_strb, 4);
    access(0, 0, 22'h9, 0, 0);
    chk(m_strb == 9, "R13 new timing applied", m_strb, 9);
  endtask

  initial begin
    set_cfg(0, mkcfg(2, 4, 1, 1, 3, 2, 2, 0, 0));
    set_cfg(1, mkcfg(3, 5, 2, 0, 2, 0, 1, 0, 0));
    set_cfg(2, mkcfg(1, 0, 0, 1, 1, 0, 0, 0, 0));
    set_cfg(3, mkcfg(2, 5, 2, 1, 3, 1, 1, 1, 0));
    t_reset();
    t_read();
    t_write();
    t_zero_strobe();
    t_b2b(2, 4);
    t_b2b(0, 2);
    t_ss();
    t_wait_release();
    t_timeout();
    t_ew_off();
    t_cfg_latch();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule